// File: doc/BRIEF.md
# 8-bit ALU with Processor Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor core. Each cycle it takes an operation code, a primary operand (the accumulator, an index register or a memory destination), a secondary operand and the current processor status byte. It forms the result and the next status byte. Both are captured in output registers at the next rising clock edge. Every operation changes only its own set of the N, V, Z and C flags, and every other status bit comes through unchanged.

The status byte keeps its usual layout: N is bit 7, V is bit 6, D is bit 3, I is bit 2, Z is bit 1 and C is bit 0. Bits 5 and 4 are copied through untouched. A write-enable output tells the register file or memory port whether to store the result. Compare, bit-test and the flag set/clear operations leave it low. Decimal-mode arithmetic is not implemented: the D bit is stored and can be changed only by its own set/clear operations, and it has no effect on sums.

Top module: `alu8_flags`

## Requirements
- R1: While rst_n is low, res_o, stat_o and wr_o are all zero.
- R2: Outputs are registered. A change on the inputs is visible on the outputs only after the next rising clock edge.
- R3: Opcode 0 (add with carry) gives res = a + b + C modulo 256 and sets C to the carry out, V to signed overflow, N to bit 7 and Z to (res == 0). wr = 1.
- R4: Opcode 1 (subtract with borrow) gives res = a - b - (1 - C) modulo 256. C = 1 means no borrow. V is signed overflow of a + ~b + C, and N and Z come from the result. wr = 1.
- R5: Opcodes 2 (AND), 3 (OR) and 4 (XOR) write the bitwise result, update N and Z only, and leave V and C as they came in. wr = 1.
- R6: Opcodes 7 (increment) and 8 (decrement) write a + 1 and a - 1, wrapping modulo 256, and update N and Z only. wr = 1.
- R7: Opcode 9 (shift left) moves bit 7 into C and fills bit 0 with 0. Opcode 10 (shift right) moves bit 0 into C, fills bit 7 with 0 and so clears N. Both update N, Z and C. wr = 1.
- R8: Opcode 11 (rotate left) moves C into bit 0 and bit 7 into C. Opcode 12 (rotate right) moves C into bit 7 and bit 0 into C. Both update N, Z and C. wr = 1.
- R9: Opcode 5 (compare) forms a - b. It sets C = 1 when a >= b unsigned, sets Z when they are equal and takes N from bit 7 of the difference. V is unchanged, wr = 0 and res equals a.
- R10: Opcode 6 (bit test) sets Z when (a & b) == 0, copies b bit 7 to N and b bit 6 to V, and leaves C unchanged. wr = 0 and res equals a.
- R11: Opcodes 16 to 22 clear C, set C, clear D, set D, clear I, set I and clear V, in that order. Each changes only its named bit. wr = 0 and res equals a.
- R12: The D bit has no effect on add or subtract results, and no opcode other than 18 and 19 changes it.
- R13: Every unlisted opcode (13 to 15 and 23 to 31) leaves the status unchanged, gives res equal to a and wr = 0. On every opcode, status bits 5 and 4 are copied from the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Primary operand (accumulator / destination) |
| b_i | input | 8 | Secondary operand (source) |
| p_i | input | 8 | Current status byte |
| res_o | output | 8 | Registered result |
| stat_o | output | 8 | Registered next status byte |
| wr_o | output | 1 | Registered result-write enable |

## Verification
The add and subtract paths get operand pairs that sit at the signed and unsigned boundaries: 0x7F+0x01, 0x80-0x01, 0xFF+0x00 with carry in, and 0x00-0x00 with no carry in. These separate a correct overflow term from a carry-derived one, and show the inverted-borrow convention. Compare is tried with a below, equal to and above b, which tells the no-borrow carry apart from a plain sign test. Shifts and rotates are tried with both carry-in values and with one-hot operands, so a rotate that ignores C or a shift that fills from C shows up. Random opcodes across the full 5-bit range, with random operands and status, are checked against the per-operation flag masks, including the reserved codes and the D bit.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADC = 5'd0,
        OP_SBC = 5'd1,
        OP_AND = 5'd2,
        OP_ORA = 5'd3,
        OP_EOR = 5'd4,
        OP_CMP = 5'd5,
        OP_BIT = 5'd6,
        OP_INC = 5'd7,
        OP_DEC = 5'd8,
        OP_ASL = 5'd9,
        OP_LSR = 5'd10,
        OP_ROL = 5'd11,
        OP_ROR = 5'd12,
        OP_CLC = 5'd16,
        OP_SEC = 5'd17,
        OP_CLD = 5'd18,
        OP_SED = 5'd19,
        OP_CLI = 5'd20,
        OP_SEI = 5'd21,
        OP_CLV = 5'd22
    } alu_op_e;

    // Status bit positions are architectural: software decodes them.
    localparam int BIT_N = 7;
    localparam int BIT_V = 6;
    localparam int BIT_D = 3;
    localparam int BIT_I = 2;
    localparam int BIT_Z = 1;
    localparam int BIT_C = 0;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } nvzc_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;

    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        full   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_i};
        sum_o  = full[MSB:0];
        cout_o = full[WIDTH];
        ovf_o  = (a_i[MSB] == b_eff[MSB]) && (full[MSB] != a_i[MSB]);
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       sel_i,   // 0 and, 1 or, 2 xor
    output logic [WIDTH-1:0] res_o
);
    always_comb begin
        unique case (sel_i)
            2'd1:    res_o = a_i | b_i;
            2'd2:    res_o = a_i ^ b_i;
            default: res_o = a_i & b_i;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic             cin_i,
    input  logic             right_i,
    input  logic             rot_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);
    localparam int MSB = WIDTH - 1;

    logic fill;

    always_comb begin
        fill = rot_i & cin_i;
        if (right_i) begin
            res_o  = {fill, a_i[MSB:1]};
            cout_o = a_i[0];
        end else begin
            res_o  = {a_i[MSB-1:0], fill};
            cout_o = a_i[MSB];
        end
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [7:0]       p_i,
    output logic [WIDTH-1:0] res_o,
    output logic [7:0]       stat_o,
    output logic             wr_o
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic [7:0]       stat;
        logic             wr;
    } out_t;

    out_t out_d, out_q;

    // main adder: add, subtract, compare
    logic             as_sub, as_cin, as_cout, as_ovf;
    logic [WIDTH-1:0] as_sum;
    // step adder: increment, decrement
    logic             st_dec, st_cout, st_ovf;
    logic [WIDTH-1:0] st_sum;
    // logic and shift units
    logic [1:0]       lg_sel;
    logic [WIDTH-1:0] lg_res, sh_res;
    logic             sh_right, sh_rot, sh_cout;

    always_comb begin
        as_sub   = (op_i == OP_SBC) || (op_i == OP_CMP);
        as_cin   = (op_i == OP_CMP) ? 1'b1 : p_i[BIT_C];
        st_dec   = (op_i == OP_DEC);
        lg_sel   = (op_i == OP_ORA) ? 2'd1 : (op_i == OP_EOR) ? 2'd2 : 2'd0;
        sh_right = (op_i == OP_LSR) || (op_i == OP_ROR);
        sh_rot   = (op_i == OP_ROL) || (op_i == OP_ROR);
    end

    alu8_addsub #(.WIDTH(WIDTH)) u_main (
        .a_i(a_i), .b_i(b_i), .cin_i(as_cin), .sub_i(as_sub),
        .sum_o(as_sum), .cout_o(as_cout), .ovf_o(as_ovf)
    );

    alu8_addsub #(.WIDTH(WIDTH)) u_step (
        .a_i(a_i), .b_i({{(WIDTH-1){1'b0}}, 1'b1}), .cin_i(st_dec), .sub_i(st_dec),
        .sum_o(st_sum), .cout_o(st_cout), .ovf_o(st_ovf)
    );

    alu8_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i(a_i), .b_i(b_i), .sel_i(lg_sel), .res_o(lg_res)
    );

    alu8_shift #(.WIDTH(WIDTH)) u_shift (
        .a_i(a_i), .cin_i(p_i[BIT_C]), .right_i(sh_right), .rot_i(sh_rot),
        .res_o(sh_res), .cout_o(sh_cout)
    );

    nvzc_t            fl;     // candidate flag values
    nvzc_t            msk;    // which flags the operation owns
    logic [WIDTH-1:0] zsrc;   // value Z is derived from

    always_comb begin
        out_d      = '0;
        out_d.res  = a_i;
        out_d.stat = p_i;
        out_d.wr   = 1'b0;
        fl         = '0;
        msk        = '0;
        zsrc       = a_i;

        case (op_i)
            OP_ADC, OP_SBC: begin
                out_d.res = as_sum;
                out_d.wr  = 1'b1;
                zsrc      = as_sum;
                fl        = '{n: as_sum[MSB], v: as_ovf, z: 1'b0, c: as_cout};
                msk       = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
            end
            OP_AND, OP_ORA, OP_EOR: begin
                out_d.res = lg_res;
                out_d.wr  = 1'b1;
                zsrc      = lg_res;
                fl.n      = lg_res[MSB];
                msk       = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
            end
            OP_CMP: begin
                zsrc = as_sum;
                fl   = '{n: as_sum[MSB], v: 1'b0, z: 1'b0, c: as_cout};
                msk  = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
            end
            OP_BIT: begin
                zsrc = lg_res;
                fl   = '{n: b_i[MSB], v: b_i[MSB-1], z: 1'b0, c: 1'b0};
                msk  = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b0};
            end
            OP_INC, OP_DEC: begin
                out_d.res = st_sum;
                out_d.wr  = 1'b1;
                zsrc      = st_sum;
                fl.n      = st_sum[MSB];
                msk       = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
            end
            OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                out_d.res = sh_res;
                out_d.wr  = 1'b1;
                zsrc      = sh_res;
                fl        = '{n: sh_res[MSB], v: 1'b0, z: 1'b0, c: sh_cout};
                msk       = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
            end
            OP_CLC: out_d.stat[BIT_C] = 1'b0;
            OP_SEC: out_d.stat[BIT_C] = 1'b1;
            OP_CLD: out_d.stat[BIT_D] = 1'b0;
            OP_SED: out_d.stat[BIT_D] = 1'b1;
            OP_CLI: out_d.stat[BIT_I] = 1'b0;
            OP_SEI: out_d.stat[BIT_I] = 1'b1;
            OP_CLV: out_d.stat[BIT_V] = 1'b0;
            default: ;
        endcase

        fl.z = (zsrc == '0);
        if (msk.n) out_d.stat[BIT_N] = fl.n;
        if (msk.v) out_d.stat[BIT_V] = fl.v;
        if (msk.z) out_d.stat[BIT_Z] = fl.z;
        if (msk.c) out_d.stat[BIT_C] = fl.c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_o  = out_q.res;
    assign stat_o = out_q.stat;
    assign wr_o   = out_q.wr;

endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       op_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [7:0]       p_i,
    input logic [WIDTH-1:0] res_o,
    input logic [7:0]       stat_o,
    input logic             wr_o
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        if (!rst_n) begin
            a_r1_reset_zero: assert (res_o == '0 && stat_o == 8'h00 && wr_o == 1'b0);
        end
    end

    a_r13_reserved_bits: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stat_o[5:4] == $past(p_i[5:4]));

    a_r9_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_CMP |=> !wr_o && res_o == $past(a_i) && stat_o[BIT_V] == $past(p_i[BIT_V]));

    a_r10_bit_nv: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_BIT |=> stat_o[BIT_N] == $past(b_i[MSB]) && stat_o[BIT_V] == $past(b_i[MSB-1])
                           && !wr_o && stat_o[BIT_C] == $past(p_i[BIT_C]));

    a_r5_logic_keeps_vc: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_AND || op_i == OP_ORA || op_i == OP_EOR)
        |=> stat_o[BIT_V] == $past(p_i[BIT_V]) && stat_o[BIT_C] == $past(p_i[BIT_C]) && wr_o);

    a_r12_d_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_CLD && op_i != OP_SED) |=> stat_o[BIT_D] == $past(p_i[BIT_D]));

    a_r3_adc_sum: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_ADC |=> {stat_o[BIT_C], res_o}
            == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + {{WIDTH{1'b0}}, $past(p_i[BIT_C])}));

    a_r7_lsr_clears_n: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_LSR |=> !stat_o[BIT_N] && stat_o[BIT_C] == $past(a_i[0]));

    a_r13_undefined_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i > 5'd12 && op_i < 5'd16) || op_i > 5'd22)
        |=> stat_o == $past(p_i) && res_o == $past(a_i) && !wr_o);

endmodule

bind alu8_flags alu8_flags_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu8_flags_test.sv
`timescale 1ns/1ps
module alu8_flags_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] a_i = '0, b_i = '0, p_i = '0;
    logic [7:0] res_o, stat_o;
    logic       wr_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu8_flags uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i), .p_i(p_i),
        .res_o(res_o), .stat_o(stat_o), .wr_o(wr_o)
    );

    // Expected {res, stat, wr} from the requirement text.
    function automatic logic [16:0] model(input logic [4:0] op, input logic [7:0] a,
                                         input logic [7:0] b, input logic [7:0] p);
        logic [7:0] r, s;
        logic       w, c;
        int         t;
        r = a; s = p; w = 1'b0; c = p[0];
        case (op)
            5'd0: begin t = a + b + c; r = t[7:0]; w = 1;
                  s[0] = t > 255; s[6] = (a[7] == b[7]) && (r[7] != a[7]);
                  s[7] = r[7]; s[1] = (r == 0); end
            5'd1: begin t = a - b - (c ? 0 : 1); r = t[7:0]; w = 1;
                  s[0] = (t >= 0); s[6] = (a[7] != b[7]) && (r[7] != a[7]);
                  s[7] = r[7]; s[1] = (r == 0); end
            5'd2, 5'd3, 5'd4: begin
                  r = (op == 2) ? (a & b) : (op == 3) ? (a | b) : (a ^ b); w = 1;
                  s[7] = r[7]; s[1] = (r == 0); end
            5'd5: begin t = a - b; s[0] = (a >= b); s[1] = (a == b); s[7] = t[7]; end
            5'd6: begin s[1] = ((a & b) == 0); s[7] = b[7]; s[6] = b[6]; end
            5'd7, 5'd8: begin r = (op == 7) ? a + 8'd1 : a - 8'd1; w = 1;
                  s[7] = r[7]; s[1] = (r == 0); end
            5'd9:  begin r = {a[6:0], 1'b0}; s[0] = a[7]; w = 1; s[7] = r[7]; s[1] = (r == 0); end
            5'd10: begin r = {1'b0, a[7:1]}; s[0] = a[0]; w = 1; s[7] = r[7]; s[1] = (r == 0); end
            5'd11: begin r = {a[6:0], c};    s[0] = a[7]; w = 1; s[7] = r[7]; s[1] = (r == 0); end
            5'd12: begin r = {c, a[7:1]};    s[0] = a[0]; w = 1; s[7] = r[7]; s[1] = (r == 0); end
            5'd16: s[0] = 0;
            5'd17: s[0] = 1;
            5'd18: s[3] = 0;
            5'd19: s[3] = 1;
            5'd20: s[2] = 0;
            5'd21: s[2] = 1;
            5'd22: s[6] = 0;
            default: ;
        endcase
        return {r, s, w};
    endfunction

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'd0: return "R3";
            5'd1: return "R4";
            5'd2, 5'd3, 5'd4: return "R5";
            5'd5: return "R9";
            5'd6: return "R10";
            5'd7, 5'd8: return "R6";
            5'd9, 5'd10: return "R7";
            5'd11, 5'd12: return "R8";
            5'd16, 5'd17, 5'd20, 5'd21, 5'd22: return "R11";
            5'd18, 5'd19: return "R12";
            default: return "R13";
        endcase
    endfunction

    task automatic check(input string tag, input logic [16:0] got, input logic [16:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got res=%02h stat=%02h wr=%0b expected res=%02h stat=%02h wr=%0b",
                     tag, got[16:9], got[8:1], got[0], exp[16:9], exp[8:1], exp[0]);
        end
    endtask

    // Drive just after a rising edge, sample just after the next one.
    task automatic apply(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] p, input string tag);
        op_i = op; a_i = a; b_i = b; p_i = p;
        @(posedge clk); #1;
        check(tag, {res_o, stat_o, wr_o}, model(op, a, b, p));
    endtask

    initial begin
        logic [16:0] prev;
        void'($urandom(32'h5eed_1234));
        #1;
        op_i = 5'd0; a_i = 8'hFF; b_i = 8'h01; p_i = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {res_o, stat_o, wr_o}, 17'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R2: outputs must hold until the edge
        apply(5'd7, 8'h10, 8'h00, 8'h00, "R6 inc");
        prev = {res_o, stat_o, wr_o};
        op_i = 5'd8; a_i = 8'h00;
        #1;
        check("R2 hold before edge", {res_o, stat_o, wr_o}, prev);
        @(posedge clk); #1;
        check("R2 update after edge", {res_o, stat_o, wr_o}, model(5'd8, 8'h00, 8'h00, 8'h00));

        // directed corners
        apply(5'd0, 8'h7F, 8'h01, 8'h00, "R3 signed overflow");
        apply(5'd0, 8'hFF, 8'h00, 8'h01, "R3 carry wrap to zero");
        apply(5'd0, 8'h80, 8'h80, 8'h00, "R3 neg overflow");
        apply(5'd1, 8'h80, 8'h01, 8'h01, "R4 signed overflow");
        apply(5'd1, 8'h00, 8'h00, 8'h00, "R4 borrow in");
        apply(5'd1, 8'h05, 8'h03, 8'h01, "R4 no borrow");
        apply(5'd0, 8'h09, 8'h01, 8'h08, "R12 decimal ignored add");
        apply(5'd1, 8'h10, 8'h01, 8'h09, "R12 decimal ignored sub");
        apply(5'd2, 8'hF0, 8'h0F, 8'h41, "R5 and zero keeps VC");
        apply(5'd4, 8'hAA, 8'h2A, 8'h00, "R5 xor negative");
        apply(5'd7, 8'hFF, 8'h00, 8'h41, "R6 inc wrap");
        apply(5'd8, 8'h00, 8'h00, 8'h00, "R6 dec wrap");
        apply(5'd5, 8'h10, 8'h20, 8'h40, "R9 cmp below");
        apply(5'd5, 8'h20, 8'h20, 8'h00, "R9 cmp equal");
        apply(5'd5, 8'h30, 8'h20, 8'h00, "R9 cmp above");
        apply(5'd6, 8'h01, 8'hC0, 8'h01, "R10 bit zero NV set");
        apply(5'd6, 8'h40, 8'h41, 8'hC0, "R10 bit nonzero");
        apply(5'd9, 8'h80, 8'h00, 8'h00, "R7 asl out");
        apply(5'd10, 8'h01, 8'h00, 8'h81, "R7 lsr clears N");
        apply(5'd11, 8'h80, 8'h00, 8'h01, "R8 rol carry in");
        apply(5'd12, 8'h01, 8'h00, 8'h01, "R8 ror carry in");
        apply(5'd12, 8'h02, 8'h00, 8'h00, "R8 ror no carry");
        for (int k = 16; k <= 22; k++) begin
            apply(5'(k), 8'h5A, 8'h00, 8'h00, req_of(5'(k)));
            apply(5'(k), 8'h5A, 8'h00, 8'hFF, req_of(5'(k)));
        end
        apply(5'd13, 8'h33, 8'h44, 8'h35, "R13 reserved 13");
        apply(5'd31, 8'h00, 8'hFF, 8'hFF, "R13 reserved 31");

        // random sweep
        for (int i = 0; i < 600; i++) begin
            logic [4:0] op;
            op = 5'($urandom_range(0, 31));
            apply(op, 8'($urandom), 8'($urandom), 8'($urandom), req_of(op));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule